// File: doc/BRIEF.md
# Deductive Fault-List Propagation Engine

This block carries out one vector of deductive fault simulation in hardware. Every line of a small levelized netlist carries a bit vector with one bit per fault ID. A set bit means that the fault, if present, would flip that line away from its fault-free value. A table holds one entry per line. Entries below a fixed count describe primary inputs. Each later entry describes a gate with these fields:
- its controlling value and inversion flag;
- a one-input marker for buffers and inverters;
- two source line indices;
- the fault IDs, each with a valid flag, of the output line's stuck-at-0 and stuck-at-1 faults.

A `start` pulse latches an input vector, a primary-output selection and a fault-set mask. The engine then spends one cycle per line in table order. In each cycle it computes the line's fault-free value and its fault list from the values and lists already stored for the source lines. The lists of the selected output lines are ORed into the set found by this vector. That set is also added to a running set of detected faults. Faults detected by earlier vectors are cleared from every list computed afterwards. The running set can be emptied when a new vector starts.

Top module: `dfl_engine`

## Requirements
- R1: A primary-input line (index below NPI) takes its applied bit as its value. Its list holds only its own stuck-at fault opposite to that value (the stuck-at-0 ID when the value is 1, the stuck-at-1 ID when it is 0).
- R2: For a two-input gate where neither input equals the controlling value c, the output value is (not c) XOR inv. The list is the union of both input lists plus the output fault opposite to the output value.
- R3: For a two-input gate where one or both inputs equal c, the output value is c XOR inv. The list is built in three steps:
  - take the intersection of the lists of the inputs at c;
  - remove every fault in the lists of the inputs not at c;
  - add the output fault opposite to the output value.
- R4: A one-input gate (buffer or inverter) outputs its source value XOR inv. Its list is the source list plus the output fault opposite to the output value.
- R5: A line fault is added only when its valid flag is set and its bit in the latched fault-set mask is 1.
- R6: `done` is a single-cycle pulse seen on the (NL+1)th cycle after the cycle in which `start` was sampled. `busy` is high from the cycle after `start` until `done`.
- R7: `fresh` is the OR of the lists of all selected output lines for the vector. `detected` accumulates `fresh` across vectors. Every fault already in `detected` when a vector starts is absent from all of that vector's lists. Both `fresh` and `detected` are zero after reset.
- R8: When `new_set` is high together with `start`, the accumulated set and the dropped set are both cleared before the vector is processed.
- R9: A `start` pulse while `busy` is high has no effect on the vector in progress.
- R10: `line_val` bit k gives the fault-free value of line k after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Writes one table entry |
| tbl_addr | input | AW | Line index of the entry |
| tbl_ctrl | input | 1 | Controlling value of the gate |
| tbl_inv | input | 1 | Output inversion flag |
| tbl_unary | input | 1 | Marks a one-input gate |
| tbl_src0 | input | AW | First source line |
| tbl_src1 | input | AW | Second source line |
| tbl_f0_id | input | IW | Fault ID of the line's stuck-at-0 |
| tbl_f0_ok | input | 1 | Stuck-at-0 fault is in the set |
| tbl_f1_id | input | IW | Fault ID of the line's stuck-at-1 |
| tbl_f1_ok | input | 1 | Stuck-at-1 fault is in the set |
| fault_en | input | NF | Collapsed fault-set mask |
| start | input | 1 | Begins one vector |
| new_set | input | 1 | Clears accumulated detections at start |
| pi_vec | input | NPI | Applied primary-input values |
| po_sel | input | NL | Lines treated as primary outputs |
| busy | output | 1 | Vector in progress |
| done | output | 1 | Vector finished (one cycle) |
| line_val | output | NL | Fault-free line values |
| fresh | output | NF | Faults detected by this vector |
| detected | output | NF | Accumulated detected faults |

## Verification
The hardest case to reach is a fault being dropped, because a single vector never exercises it. It shows up only when a fault caught by one vector would also have reached an output under a later vector. The stimulus keeps the running set across all eight input patterns of a fixed netlist and compares `fresh` against a model that carries its own drop set. Each line's list is also brought out on its own by selecting that single line as the only output, with `new_set` raised.

// File: rtl/dfl_engine.sv
module dfl_engine #(
  parameter int NF  = 16,
  parameter int NL  = 8,
  parameter int NPI = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tbl_we,
  input  logic [$clog2(NL)-1:0]    tbl_addr,
  input  logic                     tbl_ctrl,
  input  logic                     tbl_inv,
  input  logic                     tbl_unary,
  input  logic [$clog2(NL)-1:0]    tbl_src0,
  input  logic [$clog2(NL)-1:0]    tbl_src1,
  input  logic [$clog2(NF)-1:0]    tbl_f0_id,
  input  logic                     tbl_f0_ok,
  input  logic [$clog2(NF)-1:0]    tbl_f1_id,
  input  logic                     tbl_f1_ok,
  input  logic [NF-1:0]            fault_en,
  input  logic                     start,
  input  logic                     new_set,
  input  logic [NPI-1:0]           pi_vec,
  input  logic [NL-1:0]            po_sel,
  output logic                     busy,
  output logic                     done,
  output logic [NL-1:0]            line_val,
  output logic [NF-1:0]            fresh,
  output logic [NF-1:0]            detected
);
  localparam int AW = $clog2(NL);
  localparam int IW = $clog2(NF);
  localparam logic [AW-1:0] LAST = AW'(NL - 1);
  localparam logic [AW:0]   NPI_W = (AW + 1)'(NPI);

  logic          ctrl_t  [NL];
  logic          inv_t   [NL];
  logic          un_t    [NL];
  logic [AW-1:0] src0_t  [NL];
  logic [AW-1:0] src1_t  [NL];
  logic [IW-1:0] f0_t    [NL];
  logic [IW-1:0] f1_t    [NL];
  logic          f0ok_t  [NL];
  logic          f1ok_t  [NL];

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      ctrl_t[tbl_addr] <= tbl_ctrl;
      inv_t[tbl_addr]  <= tbl_inv;
      un_t[tbl_addr]   <= tbl_unary;
      src0_t[tbl_addr] <= tbl_src0;
      src1_t[tbl_addr] <= tbl_src1;
      f0_t[tbl_addr]   <= tbl_f0_id;
      f1_t[tbl_addr]   <= tbl_f1_id;
      f0ok_t[tbl_addr] <= tbl_f0_ok;
      f1ok_t[tbl_addr] <= tbl_f1_ok;
    end
  end

  logic [AW-1:0]  idx;
  logic [NL-1:0]  val_q;
  logic [NF-1:0]  list_q [NL];
  logic [NPI-1:0] pi_q;
  logic [NL-1:0]  po_q;
  logic [NF-1:0]  fen_q;
  logic [NF-1:0]  drop_q;

  logic          c, iv, un, va, vb, a_c, b_c, is_pi, nv, fok;
  logic [NF-1:0] la, lb, base, own, nl;
  logic [IW-1:0] fid;

  assign c     = ctrl_t[idx];
  assign iv    = inv_t[idx];
  assign un    = un_t[idx];
  assign va    = val_q[src0_t[idx]];
  assign vb    = val_q[src1_t[idx]];
  assign la    = list_q[src0_t[idx]];
  assign lb    = list_q[src1_t[idx]];
  assign a_c   = (va == c);
  assign b_c   = !un && (vb == c);
  assign is_pi = ({1'b0, idx} < NPI_W);

  always_comb begin
    if (is_pi)             nv = pi_q[idx[$clog2(NPI)-1:0]];
    else if (un)           nv = va ^ iv;
    else if (a_c || b_c)   nv = c ^ iv;
    else                   nv = ~c ^ iv;

    if (is_pi)             base = '0;
    else if (un)           base = la;
    else if (!a_c && !b_c) base = la | lb;
    else if (a_c && b_c)   base = la & lb;
    else if (a_c)          base = la & ~lb;
    else                   base = lb & ~la;
  end

  assign fid = nv ? f0_t[idx] : f1_t[idx];
  assign fok = nv ? f0ok_t[idx] : f1ok_t[idx];
  assign own = fok ? (({{(NF-1){1'b0}}, 1'b1} << fid) & fen_q) : '0;
  assign nl  = (base | own) & ~drop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      idx      <= '0;
      val_q    <= '0;
      pi_q     <= '0;
      po_q     <= '0;
      fen_q    <= '0;
      drop_q   <= '0;
      fresh    <= '0;
      detected <= '0;
      for (int k = 0; k < NL; k++) list_q[k] <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        idx    <= '0;
        pi_q   <= pi_vec;
        po_q   <= po_sel;
        fen_q  <= fault_en;
        fresh  <= '0;
        if (new_set) begin
          drop_q   <= '0;
          detected <= '0;
        end else begin
          drop_q <= detected;
        end
      end else if (busy) begin
        val_q[idx]  <= nv;
        list_q[idx] <= nl;
        if (po_q[idx]) begin
          fresh    <= fresh | nl;
          detected <= detected | nl;
        end
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign line_val = val_q;

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == LAST) |=> (done && !busy));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != LAST) |=> (busy && idx == AW'($past(idx) + 1'b1)));
  assert_detected_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((detected & $past(detected)) == $past(detected)));
  assert_fresh_within_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((fresh & ~detected) == '0));
endmodule

// File: tb/dfl_engine_test.sv
module dfl_engine_test;
  localparam int NF = 16, NL = 8, NPI = 3;

  logic clk = 0, rst_n = 0;
  logic tbl_we = 0, tbl_ctrl = 0, tbl_inv = 0, tbl_unary = 0;
  logic [2:0] tbl_addr = 0, tbl_src0 = 0, tbl_src1 = 0;
  logic [3:0] tbl_f0_id = 0, tbl_f1_id = 0;
  logic tbl_f0_ok = 0, tbl_f1_ok = 0;
  logic [NF-1:0] fault_en = 0;
  logic start = 0, new_set = 0;
  logic [NPI-1:0] pi_vec = 0;
  logic [NL-1:0] po_sel = 0;
  logic busy, done;
  logic [NL-1:0] line_val;
  logic [NF-1:0] fresh, detected;

  always #10 clk = ~clk;

  dfl_engine #(.NF(NF), .NL(NL), .NPI(NPI)) uut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_ctrl(tbl_ctrl), .tbl_inv(tbl_inv), .tbl_unary(tbl_unary),
    .tbl_src0(tbl_src0), .tbl_src1(tbl_src1), .tbl_f0_id(tbl_f0_id),
    .tbl_f0_ok(tbl_f0_ok), .tbl_f1_id(tbl_f1_id), .tbl_f1_ok(tbl_f1_ok),
    .fault_en(fault_en), .start(start), .new_set(new_set), .pi_vec(pi_vec),
    .po_sel(po_sel), .busy(busy), .done(done), .line_val(line_val),
    .fresh(fresh), .detected(detected));

  int checks = 0, failures = 0;

  logic m_c [NL], m_i [NL], m_u [NL], m_o0 [NL], m_o1 [NL];
  int   m_s0 [NL], m_s1 [NL], m_f0 [NL], m_f1 [NL];
  logic [NL-1:0] mv;
  logic [NF-1:0] ml [NL];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] pi, input logic [NF-1:0] fen, input logic [NF-1:0] drop);
    for (int k = 0; k < NL; k++) begin
      logic va, vb, ac, bc, v;
      logic [NF-1:0] la, lb, b, own;
      va = mv[m_s0[k]]; vb = mv[m_s1[k]];
      la = ml[m_s0[k]]; lb = ml[m_s1[k]];
      ac = (va == m_c[k]); bc = !m_u[k] && (vb == m_c[k]);
      if (k < NPI) begin v = pi[k]; b = 0; end
      else if (m_u[k]) begin v = va ^ m_i[k]; b = la; end
      else if (!ac && !bc) begin v = !m_c[k] ^ m_i[k]; b = la | lb; end
      else begin
        v = m_c[k] ^ m_i[k];
        b = ac && bc ? (la & lb) : ac ? (la & ~lb) : (lb & ~la);
      end
      if (v) own = m_o0[k] ? (16'h1 << m_f0[k]) & fen : 0;
      else   own = m_o1[k] ? (16'h1 << m_f1[k]) & fen : 0;
      mv[k] = v;
      ml[k] = (b | own) & ~drop;
    end
  endfunction

  function automatic string kind(input int k);
    if (k < NPI) return "R1";
    if (m_u[k]) return "R4";
    if (mv[m_s0[k]] != m_c[k] && mv[m_s1[k]] != m_c[k]) return "R2";
    return "R3";
  endfunction

  task automatic load(input int s);
    for (int k = 0; k < NL; k++) begin
      m_c[k]  = ((k + s) % 2) == 1;
      m_i[k]  = (((k * s) / 2) % 2) == 1;
      m_u[k]  = ((k + 2 * s) % 4) == 0;
      m_s0[k] = k > 0 ? (k * 3 + s) % k : 0;
      m_s1[k] = k > 0 ? (k * 5 + s + 1) % k : 0;
      m_f0[k] = (2 * k + s) % NF;
      m_f1[k] = (2 * k + 1 + 3 * s) % NF;
      m_o0[k] = ((k + s) % 3) != 0;
      m_o1[k] = ((k * s) % 5) != 4;
      @(negedge clk);
      tbl_we = 1; tbl_addr = 3'(k);
      tbl_ctrl = m_c[k]; tbl_inv = m_i[k]; tbl_unary = m_u[k];
      tbl_src0 = 3'(m_s0[k]); tbl_src1 = 3'(m_s1[k]);
      tbl_f0_id = 4'(m_f0[k]); tbl_f1_id = 4'(m_f1[k]);
      tbl_f0_ok = m_o0[k]; tbl_f1_ok = m_o1[k];
    end
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic run_vec(input logic [2:0] pi, input logic [NL-1:0] po, input logic [NF-1:0] fen,
                         input logic ns, input logic poke, output int cyc);
    @(negedge clk);
    pi_vec = pi; po_sel = po; fault_en = fen; new_set = ns; start = 1;
    @(negedge clk);
    start = 0; new_set = 0; cyc = 1;
    while (!done && cyc < 100) begin
      if (poke && cyc == 2) begin
        pi_vec = ~pi; po_sel = ~po; fault_en = ~fen; new_set = 1; start = 1;
      end
      @(negedge clk);
      start = 0; new_set = 0;
      cyc++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    logic [NF-1:0] fens [3];
    logic [NF-1:0] acc, f;
    fens[0] = 16'hFFFF; fens[1] = 16'hA5C3; fens[2] = 16'h0000;
    repeat (3) @(negedge clk);
    check("R7 reset fresh", 32'(fresh), 0);
    check("R7 reset detected", 32'(detected), 0);
    check("R6 reset busy/done", {30'b0, busy, done}, 0);
    rst_n = 1;

    for (int s = 0; s < 4; s++) begin
      load(s);
      for (int e = 0; e < 3; e++)
        for (int v = 0; v < 8; v++)
          for (int k = 0; k < NL; k++) begin
            mv = 0;
            model(3'(v), fens[e], 0);
            run_vec(3'(v), 8'(1 << k), fens[e], 1, 0, cyc);
            if (e == 0) begin
              check(kind(k), 32'(fresh), 32'(ml[k]));
            end else begin
              check("R5", 32'(fresh), 32'(ml[k]));
            end
            check("R7 single-line detected", 32'(detected), 32'(ml[k]));
            if (k == 0) begin
              check("R10", 32'(line_val), 32'(mv));
              check("R6 latency", 32'(cyc), NL + 1);
            end
          end
    end

    load(1);
    acc = 0;
    for (int v = 0; v < 8; v++) begin
      mv = 0;
      model(3'(v), 16'hFFFF, acc);
      f = ml[5] | ml[6] | ml[7];
      run_vec(3'(v), 8'hE0, 16'hFFFF, v == 0, 0, cyc);
      acc = acc | f;
      check("R7 fresh with dropping", 32'(fresh), 32'(f));
      check("R7 accumulated", 32'(detected), 32'(acc));
      @(negedge clk);
      check("R6 done one cycle", {31'b0, done}, 0);
    end
    mv = 0;
    model(3'd3, 16'hFFFF, 0);
    run_vec(3'd3, 8'hE0, 16'hFFFF, 1, 0, cyc);
    check("R8 cleared set", 32'(detected), 32'(ml[5] | ml[6] | ml[7]));

    mv = 0;
    model(3'd5, 16'hFFFF, 0);
    run_vec(3'd5, 8'hE0, 16'hFFFF, 1, 1, cyc);
    check("R9 values unaffected", 32'(line_val), 32'(mv));
    check("R9 fresh unaffected", 32'(fresh), 32'(ml[5] | ml[6] | ml[7]));
    check("R9 latency unaffected", 32'(cyc), NL + 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule